// File: doc/BRIEF.md
# Packing SPI Data FIFO Pair

This block sits between a 32-bit register bus and an SPI shift engine. It holds two independent 32-entry queues of 32-bit entries: one carries transmit data from the bus to the engine, the other carries receive data from the engine to the bus. The bus always moves whole entries. The engine moves one SPI word at a time.

When packing is off, each entry holds one SPI word, aligned to the low end. When packing is on, one entry carries several short SPI words, starting at the low-order bits. A 2-bit size code selects the word width. A block word count, loaded at the start of each block, tells the block where the data ends. If the last entry of a block is only partly filled, the block releases it (transmit) or commits it (receive) after the final word, and the unused lanes are dropped.

The block reports how many transmit slots are free and how many receive entries are filled. It raises a DMA request in each direction when the programmed trigger level is met. Each queue can be flushed on its own. Two sticky flags record a bus write to a full transmit queue and a bus read from an empty receive queue.

Top module: `spi_pack_fifo`

## Requirements
- R1: After synchronous reset the block reports 32 free transmit slots, 0 filled receive entries and both error flags clear. The engine sides are idle until a block is started.
- R2: `tx_free` equals 32 minus the number of held transmit entries, and `rx_fill` equals the number of held receive entries. `status_word` carries `tx_free` in bits 5:0 and `rx_fill` in bits 21:16, and all other bits are zero.
- R3: With packing off, each transmit entry gives exactly one engine word, equal to the whole entry. Each engine receive word becomes one whole entry.
- R4: With packing on, the size code selects the word width: 0 = 4 bits (8 per entry), 1 = 8 bits (4 per entry), 2 = 16 bits (2 per entry), 3 = 32 bits (1 per entry). Transmit words come out of an entry starting at bit 0 and moving upward.
- R5: With packing on, received words are placed into an entry starting at bit 0 and moving upward, masked to the word width. The entry is committed once all its lanes are filled. `bus_rx_data` shows the oldest entry.
- R6: `blk_start` loads `blk_words` as the remaining word count for both directions and restarts at lane 0. After the last word of a block, a partly used transmit entry is released with its unused lanes ignored, and a partly filled receive entry is committed with zeros in the unused lanes. Engine pops and pushes are ignored while the remaining count is zero.
- R7: `dma_tx_req` is high exactly when `tx_free` is at least the transmit trigger level. Trigger codes 0, 1, 2 and 3 mean 1, 4, 8 and 16 entries.
- R8: `dma_rx_req` is high exactly when `rx_fill` is at least the receive trigger level, using the same code meanings as R7.
- R9: `tx_flush` empties the transmit queue and returns the unpacker to lane 0. A bus write or engine pop in the same cycle is ignored.
- R10: `rx_flush` empties the receive queue and discards any partly assembled entry. A bus read or engine push in the same cycle is ignored.
- R11: A bus write while the transmit queue holds 32 entries is dropped and sets `tx_ovf`. The flag stays set until `err_clr`, and a new event in the clearing cycle keeps it set.
- R12: A bus read while the receive queue is empty returns zero on `bus_rx_data` and sets `rx_unf`, which clears the same way as R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_packed | input | 1 | Packing enable |
| cfg_pack_size | input | 2 | Word width code when packing |
| cfg_tx_trig | input | 2 | Transmit trigger level code |
| cfg_rx_trig | input | 2 | Receive trigger level code |
| blk_start | input | 1 | Load block word count, restart lanes |
| blk_words | input | BLKW | Words in the block |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| err_clr | input | 1 | Clear both error flags |
| bus_tx_wr | input | 1 | Bus write strobe, transmit side |
| bus_tx_data | input | 32 | Bus write entry |
| bus_rx_rd | input | 1 | Bus read strobe, receive side |
| bus_rx_data | output | 32 | Oldest receive entry, zero if empty |
| eng_tx_pop | input | 1 | Engine takes one transmit word |
| eng_tx_word | output | 32 | Current transmit word, right-aligned |
| eng_tx_avail | output | 1 | A transmit word is available |
| eng_rx_push | input | 1 | Engine delivers one receive word |
| eng_rx_word | input | 32 | Received word, right-aligned |
| eng_rx_ready | output | 1 | A receive word can be accepted |
| tx_free | output | CW | Free transmit slots |
| rx_fill | output | CW | Filled receive entries |
| status_word | output | 32 | Packed count readback |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The hardest case to reach is a block that ends in the middle of a packed entry while the queue is also being written or flushed. In that case, the lane index, the remaining count and the queue occupancy all change together. The stimulus uses block lengths that are not multiples of the lane count in every pack size. It also issues writes and engine pops in the same cycle, and flushes after a single lane has been consumed or assembled. A behavioural queue model tracks the lane position and remaining count, and every output is compared against it each cycle.

// File: rtl/spfifo_pkg.sv
package spfifo_pkg;

    localparam int ENTRY_W = 32;

    typedef enum logic [1:0] {
        PK_NIB  = 2'd0,
        PK_BYTE = 2'd1,
        PK_HALF = 2'd2,
        PK_WORD = 2'd3
    } pack_code_e;

    typedef struct packed {
        logic       en;
        pack_code_e size;
    } pack_cfg_t;

    // Trigger code to entry threshold.
    function automatic logic [4:0] trig_entries(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    // SPI words held by one entry.
    function automatic logic [3:0] lanes_per_entry(input pack_cfg_t cfg);
        if (!cfg.en) return 4'd1;
        case (cfg.size)
            PK_NIB:  return 4'd8;
            PK_BYTE: return 4'd4;
            PK_HALF: return 4'd2;
            default: return 4'd1;
        endcase
    endfunction

    // Width in bits of one lane.
    function automatic logic [5:0] lane_width(input pack_cfg_t cfg);
        if (!cfg.en) return 6'd32;
        case (cfg.size)
            PK_NIB:  return 6'd4;
            PK_BYTE: return 6'd8;
            PK_HALF: return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [ENTRY_W-1:0] lane_mask(input logic [5:0] w);
        if (w >= 6'd32) return '1;
        return (32'd1 << w) - 32'd1;
    endfunction

endpackage

// File: rtl/spfifo_ring.sv
module spfifo_ring #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign do_push = push && !flush && (cnt_q != CW'(DEPTH));
    assign do_pop  = pop  && !flush && (cnt_q != '0);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    assign rdata = mem[rp_q];
    assign count = cnt_q;
endmodule

// File: rtl/spfifo_tx_unpack.sv
module spfifo_tx_unpack
    import spfifo_pkg::*;
#(
    parameter int BLKW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  pack_cfg_t          cfg,
    input  logic               blk_start,
    input  logic [BLKW-1:0]    blk_words,
    input  logic               flush,
    input  logic               head_valid,
    input  logic [ENTRY_W-1:0] head,
    input  logic               eng_pop,
    output logic [ENTRY_W-1:0] word,
    output logic               avail,
    output logic               release_entry
);
    logic [2:0]      lane_q;
    logic [BLKW-1:0] rem_q;
    logic [3:0]      lanes;
    logic [5:0]      width;
    logic [7:0]      shamt;
    logic            take, last_lane, last_word;

    assign lanes     = lanes_per_entry(cfg);
    assign width     = lane_width(cfg);
    assign shamt     = 8'(lane_q) * 8'(width);
    assign avail     = head_valid && (rem_q != '0);
    assign take      = eng_pop && avail && !flush && !blk_start;
    assign last_lane = ({1'b0, lane_q} == (lanes - 4'd1));
    assign last_word = (rem_q == BLKW'(1));
    assign release_entry = take && (last_lane || last_word);
    assign word      = avail ? ((head >> shamt) & lane_mask(width)) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
            rem_q  <= '0;
        end else if (blk_start) begin
            lane_q <= '0;
            rem_q  <= blk_words;
        end else if (flush) begin
            lane_q <= '0;
        end else if (take) begin
            rem_q  <= rem_q - BLKW'(1);
            lane_q <= release_entry ? 3'd0 : lane_q + 3'd1;
        end
    end
endmodule

// File: rtl/spfifo_rx_pack.sv
module spfifo_rx_pack
    import spfifo_pkg::*;
#(
    parameter int BLKW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  pack_cfg_t          cfg,
    input  logic               blk_start,
    input  logic [BLKW-1:0]    blk_words,
    input  logic               flush,
    input  logic               space,
    input  logic               eng_push,
    input  logic [ENTRY_W-1:0] eng_word,
    output logic               ready,
    output logic               commit,
    output logic [ENTRY_W-1:0] commit_data
);
    logic [2:0]         lane_q;
    logic [BLKW-1:0]    rem_q;
    logic [ENTRY_W-1:0] acc_q, merged;
    logic [3:0]         lanes;
    logic [5:0]         width;
    logic [7:0]         shamt;
    logic               take, last_lane, last_word;

    assign lanes     = lanes_per_entry(cfg);
    assign width     = lane_width(cfg);
    assign shamt     = 8'(lane_q) * 8'(width);
    assign ready     = space && (rem_q != '0);
    assign take      = eng_push && ready && !flush && !blk_start;
    assign last_lane = ({1'b0, lane_q} == (lanes - 4'd1));
    assign last_word = (rem_q == BLKW'(1));
    assign merged    = acc_q | ((eng_word & lane_mask(width)) << shamt);
    assign commit    = take && (last_lane || last_word);
    assign commit_data = merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
            rem_q  <= '0;
            acc_q  <= '0;
        end else if (blk_start) begin
            lane_q <= '0;
            rem_q  <= blk_words;
            acc_q  <= '0;
        end else if (flush) begin
            lane_q <= '0;
            acc_q  <= '0;
        end else if (take) begin
            rem_q <= rem_q - BLKW'(1);
            if (commit) begin
                lane_q <= '0;
                acc_q  <= '0;
            end else begin
                lane_q <= lane_q + 3'd1;
                acc_q  <= merged;
            end
        end
    end
endmodule

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo
    import spfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int BLKW  = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_packed,
    input  logic [1:0]      cfg_pack_size,
    input  logic [1:0]      cfg_tx_trig,
    input  logic [1:0]      cfg_rx_trig,
    input  logic            blk_start,
    input  logic [BLKW-1:0] blk_words,
    input  logic            tx_flush,
    input  logic            rx_flush,
    input  logic            err_clr,
    input  logic            bus_tx_wr,
    input  logic [31:0]     bus_tx_data,
    input  logic            bus_rx_rd,
    output logic [31:0]     bus_rx_data,
    input  logic            eng_tx_pop,
    output logic [31:0]     eng_tx_word,
    output logic            eng_tx_avail,
    input  logic            eng_rx_push,
    input  logic [31:0]     eng_rx_word,
    output logic            eng_rx_ready,
    output logic [CW-1:0]   tx_free,
    output logic [CW-1:0]   rx_fill,
    output logic [31:0]     status_word,
    output logic            tx_ovf,
    output logic            rx_unf,
    output logic            dma_tx_req,
    output logic            dma_rx_req
);
    localparam int RX_FIELD = 16;

    pack_cfg_t          cfg;
    logic [CW-1:0]      tx_cnt, rx_cnt;
    logic [ENTRY_W-1:0] tx_head, rx_head, rx_commit_data;
    logic               tx_release, rx_commit;
    logic               ovf_set, unf_set;

    always_comb begin
        cfg.en   = cfg_packed;
        cfg.size = pack_code_e'(cfg_pack_size);
    end

    spfifo_ring #(.DW(ENTRY_W), .DEPTH(DEPTH)) u_tx_ring (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush),
        .push  (bus_tx_wr),
        .wdata (bus_tx_data),
        .pop   (tx_release),
        .rdata (tx_head),
        .count (tx_cnt)
    );

    spfifo_tx_unpack #(.BLKW(BLKW)) u_unpack (
        .clk           (clk),
        .rst           (rst),
        .cfg           (cfg),
        .blk_start     (blk_start),
        .blk_words     (blk_words),
        .flush         (tx_flush),
        .head_valid    (tx_cnt != '0),
        .head          (tx_head),
        .eng_pop       (eng_tx_pop),
        .word          (eng_tx_word),
        .avail         (eng_tx_avail),
        .release_entry (tx_release)
    );

    spfifo_rx_pack #(.BLKW(BLKW)) u_pack (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .blk_start   (blk_start),
        .blk_words   (blk_words),
        .flush       (rx_flush),
        .space       (rx_cnt != CW'(DEPTH)),
        .eng_push    (eng_rx_push),
        .eng_word    (eng_rx_word),
        .ready       (eng_rx_ready),
        .commit      (rx_commit),
        .commit_data (rx_commit_data)
    );

    spfifo_ring #(.DW(ENTRY_W), .DEPTH(DEPTH)) u_rx_ring (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .push  (rx_commit),
        .wdata (rx_commit_data),
        .pop   (bus_rx_rd),
        .rdata (rx_head),
        .count (rx_cnt)
    );

    assign bus_rx_data = (rx_cnt != '0) ? rx_head : '0;
    assign tx_free     = CW'(DEPTH) - tx_cnt;
    assign rx_fill     = rx_cnt;

    always_comb begin
        status_word = '0;
        status_word[CW-1:0]        = tx_free;
        status_word[RX_FIELD+:CW]  = rx_fill;
    end

    assign dma_tx_req = (32'(tx_free) >= 32'(trig_entries(cfg_tx_trig)));
    assign dma_rx_req = (32'(rx_fill) >= 32'(trig_entries(cfg_rx_trig)));

    assign ovf_set = bus_tx_wr && !tx_flush && (tx_cnt == CW'(DEPTH));
    assign unf_set = bus_rx_rd && !rx_flush && (rx_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf <= 1'b0;
            rx_unf <= 1'b0;
        end else begin
            tx_ovf <= (tx_ovf && !err_clr) || ovf_set;
            rx_unf <= (rx_unf && !err_clr) || unf_set;
        end
    end
endmodule

// File: rtl/spfifo_checker.sv
module spfifo_checker #(
    parameter int DEPTH = 32,
    parameter int BLKW  = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            tx_flush,
    input logic            rx_flush,
    input logic            bus_tx_wr,
    input logic            eng_tx_pop,
    input logic            bus_rx_rd,
    input logic [31:0]     bus_rx_data,
    input logic            blk_start,
    input logic [BLKW-1:0] blk_words,
    input logic            eng_tx_avail,
    input logic            eng_rx_ready,
    input logic [CW-1:0]   tx_free,
    input logic [CW-1:0]   rx_fill,
    input logic            tx_ovf,
    input logic            rx_unf,
    input logic            dma_rx_req
);
    // R2
    tx_write_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_tx_wr && tx_free != '0 && !tx_flush && !eng_tx_pop)
        |=> tx_free == $past(tx_free) - CW'(1));

    // R9
    tx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> tx_free == CW'(DEPTH));

    // R10
    rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> rx_fill == '0);

    // R11
    tx_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_tx_wr && tx_free == '0 && !tx_flush) |=> tx_ovf);

    // R12
    rx_unf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rx_rd && rx_fill == '0) |-> bus_rx_data == '0);

    // R12
    rx_unf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rx_rd && rx_fill == '0 && !rx_flush) |=> rx_unf);

    // R8
    rx_req_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_fill == '0) |-> !dma_rx_req);

    // R6
    blk_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_start && blk_words == '0) |=> (!eng_tx_avail && !eng_rx_ready));
endmodule

bind spi_pack_fifo spfifo_checker #(.DEPTH(DEPTH), .BLKW(BLKW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_flush     (tx_flush),
    .rx_flush     (rx_flush),
    .bus_tx_wr    (bus_tx_wr),
    .eng_tx_pop   (eng_tx_pop),
    .bus_rx_rd    (bus_rx_rd),
    .bus_rx_data  (bus_rx_data),
    .blk_start    (blk_start),
    .blk_words    (blk_words),
    .eng_tx_avail (eng_tx_avail),
    .eng_rx_ready (eng_rx_ready),
    .tx_free      (tx_free),
    .rx_fill      (rx_fill),
    .tx_ovf       (tx_ovf),
    .rx_unf       (rx_unf),
    .dma_rx_req   (dma_rx_req)
);

// File: tb/spi_pack_fifo_tb.sv
module spi_pack_fifo_tb;
    localparam int DEPTH = 32;
    localparam int BLKW  = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_packed = 1'b0;
    logic [1:0]      cfg_pack_size = 2'd0;
    logic [1:0]      cfg_tx_trig = 2'd0;
    logic [1:0]      cfg_rx_trig = 2'd0;
    logic            blk_start = 1'b0;
    logic [BLKW-1:0] blk_words = '0;
    logic            tx_flush = 1'b0, rx_flush = 1'b0, err_clr = 1'b0;
    logic            bus_tx_wr = 1'b0, bus_rx_rd = 1'b0;
    logic [31:0]     bus_tx_data = '0;
    logic [31:0]     bus_rx_data;
    logic            eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [31:0]     eng_tx_word, eng_rx_word = '0;
    logic            eng_tx_avail, eng_rx_ready;
    logic [CW-1:0]   tx_free, rx_fill;
    logic [31:0]     status_word;
    logic            tx_ovf, rx_unf, dma_tx_req, dma_rx_req;

    spi_pack_fifo #(.DEPTH(DEPTH), .BLKW(BLKW)) u_dut (.*);

    always #4 clk = ~clk;

    int checks = 0, failures = 0, cyc_n = 0;

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cyc_n);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Reference model state
    int unsigned txq[$];
    int unsigned rxq[$];
    int          m_tlane, m_trem, m_rlane, m_rrem;
    bit [31:0]   m_racc;
    bit          m_tovf, m_runf;

    function automatic int lanes_m();
        if (!cfg_packed) return 1;
        return 8 >> cfg_pack_size;
    endfunction
    function automatic int bits_m();
        if (!cfg_packed) return 32;
        return 4 << cfg_pack_size;
    endfunction
    function automatic bit [31:0] mask_m();
        if (bits_m() == 32) return 32'hFFFF_FFFF;
        return (32'd1 << bits_m()) - 32'd1;
    endfunction
    function automatic int trig_m(input logic [1:0] c);
        int t[4] = '{1, 4, 8, 16};
        return t[c];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit        av;
        bit [31:0] w;
        av = (txq.size() > 0) && (m_trem > 0);
        w  = av ? ((txq[0] >> (m_tlane * bits_m())) & mask_m()) : 32'd0;
        chk("R2 tx_free", 32'(tx_free), DEPTH - txq.size());
        chk("R2 rx_fill", 32'(rx_fill), rxq.size());
        chk("R2 status_word", status_word, (rxq.size() << 16) | (DEPTH - txq.size()));
        chk("R7 dma_tx_req", 32'(dma_tx_req), 32'((DEPTH - txq.size()) >= trig_m(cfg_tx_trig)));
        chk("R8 dma_rx_req", 32'(dma_rx_req), 32'(rxq.size() >= trig_m(cfg_rx_trig)));
        chk("R11 tx_ovf", 32'(tx_ovf), 32'(m_tovf));
        chk("R12 rx_unf", 32'(rx_unf), 32'(m_runf));
        chk("R6 eng_tx_avail", 32'(eng_tx_avail), 32'(av));
        chk("R6 eng_rx_ready", 32'(eng_rx_ready), 32'((rxq.size() < DEPTH) && (m_rrem > 0)));
        if (cfg_packed) chk("R4 eng_tx_word", eng_tx_word, w);
        else            chk("R3 eng_tx_word", eng_tx_word, w);
        chk("R5 bus_rx_data", bus_rx_data, (rxq.size() > 0) ? rxq[0] : 32'd0);
    endtask

    task automatic model_step();
        int        tsz, rsz, nl;
        bit        wr_ok, ovf_s, take, rel, rd_ok, unf_s, rtake, com;
        bit [31:0] merged;
        tsz = txq.size(); rsz = rxq.size(); nl = lanes_m();
        // transmit
        wr_ok = bus_tx_wr && !tx_flush && tsz < DEPTH;
        ovf_s = bus_tx_wr && !tx_flush && tsz == DEPTH;
        take  = eng_tx_pop && tsz > 0 && m_trem > 0 && !tx_flush && !blk_start;
        rel   = take && (m_tlane == nl - 1 || m_trem == 1);
        if (tx_flush) txq.delete();
        else begin
            if (rel) void'(txq.pop_front());
            if (wr_ok) txq.push_back(bus_tx_data);
        end
        if (blk_start) begin m_trem = blk_words; m_tlane = 0; end
        else if (tx_flush) m_tlane = 0;
        else if (take) begin m_trem--; m_tlane = rel ? 0 : m_tlane + 1; end
        m_tovf = (m_tovf && !err_clr) || ovf_s;
        // receive
        rd_ok  = bus_rx_rd && !rx_flush && rsz > 0;
        unf_s  = bus_rx_rd && !rx_flush && rsz == 0;
        rtake  = eng_rx_push && rsz < DEPTH && m_rrem > 0 && !rx_flush && !blk_start;
        merged = m_racc | ((eng_rx_word & mask_m()) << (m_rlane * bits_m()));
        com    = rtake && (m_rlane == nl - 1 || m_rrem == 1);
        if (rx_flush) rxq.delete();
        else begin
            if (rd_ok) void'(rxq.pop_front());
            if (com) rxq.push_back(merged);
        end
        if (blk_start) begin m_rrem = blk_words; m_rlane = 0; m_racc = 0; end
        else if (rx_flush) begin m_rlane = 0; m_racc = 0; end
        else if (rtake) begin
            m_rrem--;
            if (com) begin m_rlane = 0; m_racc = 0; end
            else begin m_rlane++; m_racc = merged; end
        end
        m_runf = (m_runf && !err_clr) || unf_s;
    endtask

    task automatic cyc();
        #1;
        compare_all();
        @(posedge clk);
        model_step();
        #1;
        bus_tx_wr = 0; bus_rx_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
        blk_start = 0; tx_flush = 0; rx_flush = 0; err_clr = 0;
    endtask

    task automatic start_blk(input int n);
        blk_words = BLKW'(n); blk_start = 1; cyc();
    endtask
    task automatic wr(input logic [31:0] d);
        bus_tx_wr = 1; bus_tx_data = d; cyc();
    endtask
    task automatic pops(input int n);
        for (int i = 0; i < n; i++) begin eng_tx_pop = 1; cyc(); end
    endtask
    task automatic push(input logic [31:0] d);
        eng_rx_push = 1; eng_rx_word = d; cyc();
    endtask
    task automatic reads(input int n);
        for (int i = 0; i < n; i++) begin bus_rx_rd = 1; cyc(); end
    endtask

    task automatic lane_run(input bit pk, input logic [1:0] sz, input int n);
        int ent;
        cfg_packed = pk; cfg_pack_size = sz;
        start_blk(n);
        ent = (n + lanes_m() - 1) / lanes_m();
        for (int i = 0; i < ent; i++) wr(32'hA5C3_0000 + 32'(i * 32'h0102_0304) ^ 32'h9E37_79B9);
        pops(n + 1);
        for (int i = 0; i < n; i++) push(32'hFFFF_FF00 | 32'(i * 37 + 5));
        reads(ent);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        m_tlane = 0; m_trem = 0; m_rlane = 0; m_rrem = 0; m_racc = 0;
        m_tovf = 0; m_runf = 0;
        #1;
        // R1 reset state
        chk("R1 tx_free", 32'(tx_free), 32);
        chk("R1 rx_fill", 32'(rx_fill), 0);
        chk("R1 flags", {30'd0, tx_ovf, rx_unf}, 0);
        chk("R1 engine idle", {30'd0, eng_tx_avail, eng_rx_ready}, 0);
        cyc();

        // R3 unpacked, R4/R5/R6 every pack size with partial last entries
        lane_run(1'b0, 2'd0, 3);
        lane_run(1'b1, 2'd1, 6);
        lane_run(1'b1, 2'd2, 5);
        lane_run(1'b1, 2'd0, 9);
        lane_run(1'b1, 2'd3, 2);

        // write and pop in the same cycle (R2)
        cfg_packed = 1; cfg_pack_size = 2'd2;
        start_blk(4);
        wr(32'h1111_2222);
        eng_tx_pop = 1; bus_tx_wr = 1; bus_tx_data = 32'h3333_4444; cyc();
        eng_tx_pop = 1; bus_tx_wr = 1; bus_tx_data = 32'h5555_6666; cyc();
        pops(3);
        tx_flush = 1; cyc();

        // trigger levels (R7, R8), overflow (R11), underflow (R12)
        cfg_packed = 0;
        start_blk(40);
        for (int i = 0; i < 32; i++) begin
            cfg_tx_trig = 2'(i % 4);
            wr(32'(i) + 32'h100);
        end
        wr(32'hDEAD_BEEF);
        chk("R11 overflow flag", 32'(tx_ovf), 1);
        chk("R11 dropped write", 32'(tx_free), 0);
        err_clr = 1; cyc();
        for (int i = 0; i < 20; i++) begin
            cfg_rx_trig = 2'(i % 4);
            push(32'(i * 3 + 1));
        end
        cfg_rx_trig = 2'd3;
        reads(21);
        chk("R12 underflow flag", 32'(rx_unf), 1);
        bus_rx_rd = 1; err_clr = 1; cyc();
        chk("R12 set beats clear", 32'(rx_unf), 1);
        err_clr = 1; cyc();

        // R9 flush with simultaneous write, mid-entry lane reset
        tx_flush = 1; bus_tx_wr = 1; bus_tx_data = 32'h7777_7777; cyc();
        #1;
        chk("R9 flush empties tx", 32'(tx_free), 32);
        cfg_packed = 1; cfg_pack_size = 2'd1;
        start_blk(8);
        wr(32'h4433_2211); wr(32'h8877_6655);
        pops(1);
        tx_flush = 1; cyc();
        wr(32'hCCBB_AA99);
        #1;
        chk("R9 lane restarts", eng_tx_word, 32'h99);
        pops(3);

        // R10 flush discards a partial receive entry
        start_blk(8);
        push(32'h12); push(32'h34);
        rx_flush = 1; cyc();
        push(32'h01); push(32'h02); push(32'h03); push(32'h04);
        #1;
        chk("R10 fresh entry", bus_rx_data, 32'h0403_0201);
        chk("R10 fill", 32'(rx_fill), 1);
        reads(1);

        // R6 zero-length block
        start_blk(0);
        wr(32'h5A5A_5A5A);
        pops(2);
        push(32'h77);
        cyc();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule